// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver with DMA Request

This block is the receive half of an asynchronous serial port. A free-running oversampling tick, sixteen pulses per bit period, drives it. It watches the line for a falling edge, checks the start bit at its centre and then shifts in eight data bits, least significant bit first. Each bit takes the majority of three centre samples. The frame ends with one stop bit. There is no parity. The finished byte goes into a holding register, and a ready flag is raised.

The ready flag drives a DMA request when DMA mode is on, and a byte interrupt when that interrupt is enabled. A single data-read strobe consumes the byte. That strobe serves both as the DMA engine's acknowledge and as a software read. Framing, noise and overrun conditions are reported together with the byte that carried them. A separately enabled error interrupt reports them. A status-read strobe followed by a data-read strobe clears them. An active-low ready-to-send output, with its own enable, tells the peer transmitter to hold off while the holding register is full.

Top module: `uart_rx_dma`

## Requirements
- R1: After reset, rdy_flag, frame_err, noise_err and over_err are 0, dma_req and err_irq are 0, and rts_n is 0.
- R2: After a frame of one low start bit, eight data bits sent LSB first and one high stop bit, each bit lasting 16 ticks, rx_data holds the byte and rdy_flag is 1. rdy_flag rises only in the cycle after the frame logic reports a completed frame.
- R3: A one-cycle pulse on dr_rd clears rdy_flag on the next clock edge, unless a new frame completes in the same cycle.
- R4: dma_req is 1 exactly when dma_en is 1 and rdy_flag is 1, so a request follows each stored byte until it is read.
- R5: rdy_irq is 1 exactly when rdy_irq_en is 1 and rdy_flag is 1.
- R6: If the stop bit samples low, the byte is still stored, rdy_flag is set and frame_err is 1.
- R7: A bit's value is the majority of its samples at tick positions 7, 8 and 9 within the bit. If those three disagree for any bit of the frame, noise_err is set with the byte.
- R8: If a frame completes while rdy_flag is 1 and no read occurs in that cycle, over_err is set, the new byte is dropped and rx_data keeps the old byte.
- R9: err_irq is 1 exactly when err_irq_en is 1 and at least one of frame_err, noise_err and over_err is 1. While err_irq_en is 0, err_irq stays 0.
- R10: When fc_en is 1, rts_n equals rdy_flag (high means not ready). When fc_en is 0, rts_n is held 0.
- R11: A dr_rd pulse clears all three error flags only if an st_rd pulse has occurred since the previous dr_rd. A dr_rd without a preceding st_rd leaves them unchanged.
- R12: Each stored byte rewrites frame_err and noise_err with that byte's own condition. Neither flag rises except in the cycle after a completed frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Serial line, idle high |
| os_tick | input | 1 | One-cycle oversampling pulse, 16 per bit |
| dr_rd | input | 1 | Data-register read strobe / DMA acknowledge |
| st_rd | input | 1 | Status read strobe, arms error clearing |
| dma_en | input | 1 | DMA request enable |
| rdy_irq_en | input | 1 | Byte-ready interrupt enable |
| err_irq_en | input | 1 | Error interrupt enable |
| fc_en | input | 1 | Ready-to-send flow control enable |
| rx_data | output | 8 | Holding register |
| rdy_flag | output | 1 | Byte waiting in holding register |
| frame_err | output | 1 | Stop bit sampled low |
| noise_err | output | 1 | Centre samples disagreed |
| over_err | output | 1 | Byte lost while register full |
| dma_req | output | 1 | DMA request |
| rdy_irq | output | 1 | Byte-ready interrupt |
| err_irq | output | 1 | Error interrupt |
| rts_n | output | 1 | Active-low ready-to-send |

## Verification
The assertions assume that os_tick is a single-cycle pulse and that rx_in is stable across the clocks before each tick. They also assume that dr_rd and st_rd are single-cycle strobes. The read-clears property ignores a read that coincides with frame completion. The stimulus follows these assumptions. It changes the line only at the start of a four-clock slot and raises the tick in that slot's last clock. It issues reads and status strobes only in the idle gaps between frames, when no tick is running.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rx_state_e;

  // Value of a bit from three centre samples.
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // Any disagreement among the three centre samples.
  function automatic logic disagree3(input logic a, input logic b, input logic c);
    return (a ^ b) | (b ^ c);
  endfunction
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer import uart_rx_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              fe,
  output logic              nf
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] S_LO  = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] S_MID = CNT_W'(OSR/2);
  localparam logic [CNT_W-1:0] S_HI  = CNT_W'(OSR/2 + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(OSR - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        early;
  logic [DATA_W-1:0] shreg;
  logic              noise_acc;
  logic              bit_val, bit_noise, decide, sample, bit_end;

  always_comb begin
    bit_val   = vote3(early[1], early[0], rx);
    bit_noise = disagree3(early[1], early[0], rx);
    sample    = tick && (cnt == S_LO || cnt == S_MID);
    decide    = tick && (cnt == S_HI) && (state != ST_IDLE);
    bit_end   = tick && (cnt == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      idx       <= '0;
      early     <= '0;
      shreg     <= '0;
      noise_acc <= 1'b0;
      done      <= 1'b0;
      fe        <= 1'b0;
      nf        <= 1'b0;
    end else begin
      done <= 1'b0;
      if (sample) early <= {early[0], rx};
      if (tick) begin
        if (state == ST_IDLE) begin
          if (!rx) begin
            state     <= ST_START;
            cnt       <= CNT_W'(1);
            noise_acc <= 1'b0;
          end
        end else begin
          cnt <= bit_end ? '0 : cnt + 1'b1;
        end
      end
      case (state)
        ST_START: begin
          if (decide && bit_val) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            if (decide) noise_acc <= noise_acc | bit_noise;
            if (bit_end) begin
              state <= ST_DATA;
              idx   <= '0;
            end
          end
        end
        ST_DATA: begin
          if (decide) begin
            shreg     <= {bit_val, shreg[DATA_W-1:1]};
            noise_acc <= noise_acc | bit_noise;
          end
          if (bit_end) begin
            if (idx == IDX_LAST) state <= ST_STOP;
            else                 idx   <= idx + 1'b1;
          end
        end
        ST_STOP: begin
          if (decide) begin
            done <= 1'b1;
            fe   <= !bit_val;
            nf   <= noise_acc | bit_noise;
          end
          if (bit_end) state <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign data = shreg;
endmodule

// File: rtl/rx_status.sv
module rx_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] new_data,
  input  logic              new_fe,
  input  logic              new_nf,
  input  logic              dr_rd,
  input  logic              st_rd,
  output logic [DATA_W-1:0] data,
  output logic              rdy,
  output logic              fe,
  output logic              nf,
  output logic              ore
);
  logic armed;
  logic still_full;
  logic err_clear;

  always_comb begin
    still_full = rdy && !dr_rd;
    err_clear  = dr_rd && armed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data  <= '0;
      rdy   <= 1'b0;
      fe    <= 1'b0;
      nf    <= 1'b0;
      ore   <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (dr_rd)      armed <= 1'b0;
      else if (st_rd) armed <= 1'b1;
      if (err_clear) begin
        fe  <= 1'b0;
        nf  <= 1'b0;
        ore <= 1'b0;
      end
      if (dr_rd) rdy <= 1'b0;
      if (done) begin
        if (still_full) begin
          ore <= 1'b1;
        end else begin
          data <= new_data;
          rdy  <= 1'b1;
          fe   <= new_fe;
          nf   <= new_nf;
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_dma.sv
module uart_rx_dma #(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_in,
  input  logic              os_tick,
  input  logic              dr_rd,
  input  logic              st_rd,
  input  logic              dma_en,
  input  logic              rdy_irq_en,
  input  logic              err_irq_en,
  input  logic              fc_en,
  output logic [DATA_W-1:0] rx_data,
  output logic              rdy_flag,
  output logic              frame_err,
  output logic              noise_err,
  output logic              over_err,
  output logic              dma_req,
  output logic              rdy_irq,
  output logic              err_irq,
  output logic              rts_n
);
  logic              rx_s;
  logic              frm_done;
  logic [DATA_W-1:0] frm_data;
  logic              frm_fe, frm_nf;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_in), .q(rx_s)
  );

  rx_framer #(.DATA_W(DATA_W), .OSR(OSR)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx(rx_s),
    .done(frm_done), .data(frm_data), .fe(frm_fe), .nf(frm_nf)
  );

  rx_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst_n(rst_n), .done(frm_done), .new_data(frm_data),
    .new_fe(frm_fe), .new_nf(frm_nf), .dr_rd(dr_rd), .st_rd(st_rd),
    .data(rx_data), .rdy(rdy_flag), .fe(frame_err), .nf(noise_err),
    .ore(over_err)
  );

  assign dma_req = dma_en && rdy_flag;
  assign rdy_irq = rdy_irq_en && rdy_flag;
  assign err_irq = err_irq_en && (frame_err || noise_err || over_err);
  assign rts_n   = fc_en && rdy_flag;
endmodule

// File: rtl/uart_rx_dma_chk.sv
module uart_rx_dma_chk (
  input logic clk,
  input logic rst_n,
  input logic dr_rd,
  input logic dma_en,
  input logic rdy_irq_en,
  input logic err_irq_en,
  input logic fc_en,
  input logic rdy_flag,
  input logic frame_err,
  input logic noise_err,
  input logic over_err,
  input logic dma_req,
  input logic rdy_irq,
  input logic err_irq,
  input logic rts_n,
  input logic frm_done
);
  a_r2_flag_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_flag) |-> $past(frm_done));
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    dr_rd && !frm_done |=> !rdy_flag);
  a_r4_dma_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> rdy_flag && dma_en);
  a_r4_dma_issued: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_flag && dma_en |-> dma_req);
  a_r5_rdy_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_irq |-> rdy_flag && rdy_irq_en);
  a_r8_overrun_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(over_err) |-> $past(frm_done) && $past(rdy_flag));
  a_r9_err_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
    !err_irq_en |-> !err_irq);
  a_r9_err_irq_on: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq_en && (frame_err || noise_err || over_err) |-> err_irq);
  a_r10_rts_forced_low: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_en |-> !rts_n);
  a_r10_rts_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fc_en && rdy_flag |-> rts_n);
  a_r12_fe_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> $past(frm_done));
  a_r12_nf_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(noise_err) |-> $past(frm_done));
endmodule

bind uart_rx_dma uart_rx_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dr_rd(dr_rd), .dma_en(dma_en),
  .rdy_irq_en(rdy_irq_en), .err_irq_en(err_irq_en), .fc_en(fc_en),
  .rdy_flag(rdy_flag), .frame_err(frame_err), .noise_err(noise_err),
  .over_err(over_err), .dma_req(dma_req), .rdy_irq(rdy_irq),
  .err_irq(err_irq), .rts_n(rts_n), .frm_done(frm_done)
);

// File: tb/test_uart_rx_dma.sv
module test_uart_rx_dma;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_in = 1'b1, os_tick = 1'b0, dr_rd = 1'b0, st_rd = 1'b0;
  logic dma_en = 1'b0, rdy_irq_en = 1'b0, err_irq_en = 1'b0, fc_en = 1'b1;
  logic [7:0] rx_data;
  logic rdy_flag, frame_err, noise_err, over_err, dma_req, rdy_irq, err_irq, rts_n;

  int tests = 0;
  int fails = 0;
  bit done_run = 1'b0;

  // reference model state
  logic [7:0] exp_data = 8'h00;
  bit exp_rdy = 0, exp_fe = 0, exp_nf = 0, exp_ore = 0, exp_armed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_dma i_uart_rx_dma (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .os_tick(os_tick),
    .dr_rd(dr_rd), .st_rd(st_rd), .dma_en(dma_en), .rdy_irq_en(rdy_irq_en),
    .err_irq_en(err_irq_en), .fc_en(fc_en), .rx_data(rx_data),
    .rdy_flag(rdy_flag), .frame_err(frame_err), .noise_err(noise_err),
    .over_err(over_err), .dma_req(dma_req), .rdy_irq(rdy_irq),
    .err_irq(err_irq), .rts_n(rts_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Output relations compared on every clock, from the requirement text.
  always @(negedge clk) begin
    if (rst_n && !done_run) begin
      check("R4 dma_req", dma_req, dma_en && rdy_flag);
      check("R5 rdy_irq", rdy_irq, rdy_irq_en && rdy_flag);
      check("R9 err_irq", err_irq, err_irq_en && (frame_err || noise_err || over_err));
      check("R10 rts_n", rts_n, fc_en ? rdy_flag : 1'b0);
    end
  end

  task automatic compare_model(input string req);
    check({req, " data"}, rx_data, exp_data);
    check({req, " rdy"}, rdy_flag, exp_rdy);
    check({req, " fe"}, frame_err, exp_fe);
    check({req, " nf"}, noise_err, exp_nf);
    check({req, " ore"}, over_err, exp_ore);
  endtask

  // One oversampling slot: line set, then a tick in the fourth clock.
  task automatic slot(input logic v);
    @(negedge clk) rx_in = v;
    repeat (2) @(negedge clk);
    os_tick = 1'b1;
    @(negedge clk) os_tick = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop_v, input int noisy_bit);
    for (int j = 0; j < 10; j++) begin
      logic bv;
      bv = (j == 0) ? 1'b0 : (j == 9) ? stop_v : b[j-1];
      for (int k = 0; k < 16; k++) slot((j == noisy_bit && k == 8) ? ~bv : bv);
    end
    repeat (3) slot(1'b1);
    if (exp_rdy) exp_ore = 1;
    else begin
      exp_data = b; exp_rdy = 1; exp_fe = !stop_v; exp_nf = (noisy_bit >= 0);
    end
  endtask

  task automatic read_data();
    @(negedge clk) dr_rd = 1'b1;
    @(negedge clk) dr_rd = 1'b0;
    exp_rdy = 0;
    if (exp_armed) begin exp_fe = 0; exp_nf = 0; exp_ore = 0; end
    exp_armed = 0;
    @(negedge clk);
  endtask

  task automatic read_status();
    @(negedge clk) st_rd = 1'b1;
    @(negedge clk) st_rd = 1'b0;
    exp_armed = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    compare_model("R1");
    check("R1 dma_req", dma_req, 0);
    check("R1 rts_n", rts_n, 0);
    check("R1 err_irq", err_irq, 0);

    // R2 R4 R5 R10 clean byte with DMA and interrupt on
    dma_en = 1; rdy_irq_en = 1;
    send_frame(8'hA5, 1'b1, -1);
    compare_model("R2");
    check("R4 dma_req set", dma_req, 1);
    check("R5 rdy_irq set", rdy_irq, 1);
    check("R10 rts_n high when full", rts_n, 1);
    read_data();
    check("R3 rdy cleared", rdy_flag, 0);
    check("R4 dma_req dropped", dma_req, 0);
    check("R10 rts_n low after read", rts_n, 0);

    // R10 flow control disabled
    fc_en = 0;
    send_frame(8'h3C, 1'b1, -1);
    compare_model("R2 second");
    check("R10 rts_n held low", rts_n, 0);
    read_data();
    fc_en = 1;

    // R6 R9 framing error, interrupt gated
    send_frame(8'h5A, 1'b0, -1);
    compare_model("R6");
    check("R9 err_irq off", err_irq, 0);
    err_irq_en = 1;
    @(negedge clk);
    check("R9 err_irq on", err_irq, 1);
    read_status();
    read_data();
    compare_model("R11 fe cleared");

    // R7 noise on data bit 3, majority keeps value
    send_frame(8'h81, 1'b1, 4);
    compare_model("R7");
    check("R7 noise flag", noise_err, 1);
    read_status();
    read_data();
    compare_model("R11 nf cleared");

    // R8 overrun, R11 clearing needs status read
    send_frame(8'h11, 1'b1, -1);
    send_frame(8'h22, 1'b1, -1);
    compare_model("R8");
    check("R8 old byte kept", rx_data, 8'h11);
    read_data();
    compare_model("R11 ore kept without status");
    check("R11 ore still set", over_err, 1);
    read_status();
    read_data();
    compare_model("R11 ore cleared");

    // R12 flags rewritten by next byte
    send_frame(8'h66, 1'b0, 2);
    read_data();
    compare_model("R12 kept after plain read");
    send_frame(8'h42, 1'b1, -1);
    compare_model("R12 rewritten");
    check("R12 fe from new byte", frame_err, 0);
    read_data();

    done_run = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule